// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits beside the command scheduler of a DDR2-style memory controller. Every cycle it looks at the command actually sent to the memory, which is a command type and a bank address. It then tells the scheduler which commands may legally go out in the next cycle. There is one flag per bank for each of five command kinds: row activate, column read, column write, row precharge and refresh.

All timing windows are counted in controller clock cycles. The window lengths come from a set of configuration values. A reset loads default values, and a load strobe replaces them at run time. The block keeps two kinds of saturating countdowns:

- Per-bank countdowns cover rules that concern one bank.
- Shared countdowns cover rules that span banks.

A four-entry window of activate ages enforces the rule that no more than four activates may fall inside one rolling window. The write-to-read turnaround and the write recovery time are derived from the CAS latency and the burst length. They are not given directly.

Top module: `dram_timing_guard`

## Requirements
- R1: After reset every legal flag of every bank is 1.
- R2: Activate or refresh to bank b is flagged illegal until tRC cycles have passed since b's last activate, tRP cycles since b's last precharge, and tRFC cycles since the last refresh to any bank. A refresh restarts the tRFC window for all banks.
- R3: Activate to any bank is flagged illegal until tRRD cycles have passed since the last activate to any bank.
- R4: Activate to any bank is flagged illegal until tFAW cycles have passed since the fourth most recent activate.
- R5: Read to bank b is flagged illegal until tRCD cycles have passed since b's last activate. It is also illegal until (max(CL-1,0)) + BL/2 + tWTR cycles have passed since b's last write.
- R6: Write to bank b is flagged illegal until tRCD cycles have passed since b's last activate.
- R7: Read and write to any bank are flagged illegal until tCCD cycles have passed since the last read or write to any bank.
- R8: Precharge to bank b is flagged illegal until all three of these windows have passed:
  - tRAS cycles since b's activate;
  - tRTP cycles since b's last read;
  - (max(CL-1,0)) + BL/2 + tWR cycles since b's last write.
- R9: A command counts when cmd_valid is 1 during a clock edge. It is decoded with cmd_type encoding 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. A window of t cycles started by a command in cycle c blocks cycles c+1 through c+t-1, and the flag is legal again in cycle c+t. A window of 0 or 1 blocks nothing.
- R10: Reset loads the default timing values. A cfg_load edge captures all cfg_* inputs, and the new values govern every command issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 3 | Issued command kind (R9 encoding) |
| cmd_bank | input | BAW | Bank of the issued command |
| cfg_load | input | 1 | Capture all cfg_* values at this edge |
| cfg_t_rc | input | TW | Activate-to-activate, same bank |
| cfg_t_rp | input | TW | Precharge-to-activate, same bank |
| cfg_t_rfc | input | TW | Refresh cycle time |
| cfg_t_rrd | input | TW | Activate-to-activate, any bank |
| cfg_t_faw | input | TW | Four-activate window length |
| cfg_t_rcd | input | TW | Activate-to-column command |
| cfg_t_ccd | input | TW | Column-to-column command |
| cfg_t_ras | input | TW | Activate-to-precharge minimum |
| cfg_t_rtp | input | TW | Read-to-precharge |
| cfg_t_wr | input | TW | Write recovery after the data burst |
| cfg_t_wtr | input | TW | Write-to-read after the data burst |
| cfg_cl | input | TW | CAS latency |
| cfg_bl | input | TW | Burst length |
| ok_act | output | NB | Activate legal, per bank |
| ok_rd | output | NB | Read legal, per bank |
| ok_wr | output | NB | Write legal, per bank |
| ok_pre | output | NB | Precharge legal, per bank |
| ok_ref | output | NB | Refresh legal, per bank |

## Verification
Every flag changes exactly one clock edge after the command that starts its window. A t-cycle window is first legal again t cycles after the issue cycle. The bench therefore compares all five flag vectors once per cycle at the falling edge, before driving that cycle's command. Its reference keeps the cycle number of the last command of each kind, computes each expected flag as "current cycle minus that stamp is at least the window", and advances its cycle count at each rising edge. Directed sequences cover the following; fixed-seed random legal command streams then run under two different timing sets:
- the reset state;
- the exact tRCD boundary;
- a burst of four activates against tFAW;
- windows of 0 and 1 after a configuration load.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dram_cmd_e;

  // Countdown preload for a window of t cycles: legal again t cycles later.
  function automatic int unsigned win_load(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  // Cycles from a write command to the end of its data burst.
  function automatic int unsigned burst_end(input int unsigned cl, input int unsigned bl);
    return ((cl == 0) ? 0 : cl - 1) + (bl / 2);
  endfunction

  function automatic int unsigned wr_to_rd_span(input int unsigned cl, input int unsigned bl,
                                                input int unsigned twtr);
    return burst_end(cl, bl) + twtr;
  endfunction

  function automatic int unsigned wr_to_pre_span(input int unsigned cl, input int unsigned bl,
                                                 input int unsigned twr);
    return burst_end(cl, bl) + twr;
  endfunction

endpackage

// File: rtl/dtg_countdown.sv
module dtg_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         expired
);

  logic [W-1:0] dec_val;
  logic [W-1:0] nxt_val;

  assign dec_val = (cnt == '0) ? '0 : cnt - W'(1);
  // A new window only ever lengthens the remaining wait.
  assign nxt_val = (ld && (ld_val > dec_val)) ? ld_val : dec_val;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt_val;
  end

  assign expired = (cnt == '0);

  p_sat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !ld) |=> expired);

  p_load_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt >= $past(ld_val)));

endmodule

// File: rtl/dtg_bank_timers.sv
module dtg_bank_timers #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_hit,
  input  logic          pre_hit,
  input  logic          rd_hit,
  input  logic          wr_hit,
  input  logic          ref_any,
  input  logic [CW-1:0] v_rc,
  input  logic [CW-1:0] v_rp,
  input  logic [CW-1:0] v_rfc,
  input  logic [CW-1:0] v_rcd,
  input  logic [CW-1:0] v_wtr,
  input  logic [CW-1:0] v_ras,
  input  logic [CW-1:0] v_rtp,
  input  logic [CW-1:0] v_wrr,
  output logic          act_free,
  output logic          rd_free,
  output logic          wr_free,
  output logic          pre_free
);

  // Row gate: governs activate and refresh to this bank.
  logic          row_ld;
  logic [CW-1:0] row_val;
  logic [CW-1:0] row_cnt;
  assign row_ld  = act_hit | pre_hit | ref_any;
  assign row_val = act_hit ? v_rc : (pre_hit ? v_rp : v_rfc);

  // Read gate: activate-to-read and write-to-read turnaround.
  logic          rd_ld;
  logic [CW-1:0] rd_val;
  logic [CW-1:0] rd_cnt;
  assign rd_ld  = act_hit | wr_hit;
  assign rd_val = act_hit ? v_rcd : v_wtr;

  // Write gate: activate-to-write.
  logic [CW-1:0] wr_cnt;

  // Precharge gate: row active time, read-to-precharge, write recovery.
  logic          pre_ld;
  logic [CW-1:0] pre_val;
  logic [CW-1:0] pre_cnt;
  assign pre_ld  = act_hit | rd_hit | wr_hit;
  assign pre_val = act_hit ? v_ras : (rd_hit ? v_rtp : v_wrr);

  dtg_countdown #(.W(CW)) u_row (
    .clk(clk), .rst_n(rst_n), .ld(row_ld), .ld_val(row_val),
    .cnt(row_cnt), .expired(act_free));

  dtg_countdown #(.W(CW)) u_rd (
    .clk(clk), .rst_n(rst_n), .ld(rd_ld), .ld_val(rd_val),
    .cnt(rd_cnt), .expired(rd_free));

  dtg_countdown #(.W(CW)) u_wr (
    .clk(clk), .rst_n(rst_n), .ld(act_hit), .ld_val(v_rcd),
    .cnt(wr_cnt), .expired(wr_free));

  dtg_countdown #(.W(CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .ld(pre_ld), .ld_val(pre_val),
    .cnt(pre_cnt), .expired(pre_free));

  p_rcd_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && v_rcd != '0) |=> (!rd_free && !wr_free));

  p_wtr_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && v_wtr != '0) |=> !rd_free);

  p_ras_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && v_ras != '0) |=> !pre_free);

  p_rfc_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_any && v_rfc != '0) |=> !act_free);

endmodule

// File: rtl/dtg_faw_window.sv
module dtg_faw_window #(
  parameter int DEPTH = 4,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [CW-1:0] ld_val,
  output logic          slot_free
);

  logic [CW-1:0] age     [DEPTH];
  logic [CW-1:0] age_nxt [DEPTH];
  logic [CW-1:0] age_dec [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age_dec[i] = (age[i] == '0) ? '0 : age[i] - CW'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (!act)        age_nxt[i] = age_dec[i];
      else if (i == 0) age_nxt[i] = ld_val;
      else             age_nxt[i] = age_dec[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) age[i] <= age_nxt[i];
    end
  end

  // The oldest tracked activate has left the window.
  assign slot_free = (age[DEPTH-1] == '0);

  p_faw_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && age[DEPTH-2] > CW'(1)) |=> !slot_free);

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard #(
  parameter int          NB     = 8,
  parameter int          TW     = 6,
  parameter int          BAW    = $clog2(NB),
  parameter int unsigned D_RC   = 10,
  parameter int unsigned D_RP   = 3,
  parameter int unsigned D_RFC  = 12,
  parameter int unsigned D_RRD  = 2,
  parameter int unsigned D_FAW  = 9,
  parameter int unsigned D_RCD  = 3,
  parameter int unsigned D_CCD  = 2,
  parameter int unsigned D_RAS  = 7,
  parameter int unsigned D_RTP  = 2,
  parameter int unsigned D_WR   = 3,
  parameter int unsigned D_WTR  = 2,
  parameter int unsigned D_CL   = 3,
  parameter int unsigned D_BL   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_type,
  input  logic [BAW-1:0] cmd_bank,
  input  logic           cfg_load,
  input  logic [TW-1:0]  cfg_t_rc,
  input  logic [TW-1:0]  cfg_t_rp,
  input  logic [TW-1:0]  cfg_t_rfc,
  input  logic [TW-1:0]  cfg_t_rrd,
  input  logic [TW-1:0]  cfg_t_faw,
  input  logic [TW-1:0]  cfg_t_rcd,
  input  logic [TW-1:0]  cfg_t_ccd,
  input  logic [TW-1:0]  cfg_t_ras,
  input  logic [TW-1:0]  cfg_t_rtp,
  input  logic [TW-1:0]  cfg_t_wr,
  input  logic [TW-1:0]  cfg_t_wtr,
  input  logic [TW-1:0]  cfg_cl,
  input  logic [TW-1:0]  cfg_bl,
  output logic [NB-1:0]  ok_act,
  output logic [NB-1:0]  ok_rd,
  output logic [NB-1:0]  ok_wr,
  output logic [NB-1:0]  ok_pre,
  output logic [NB-1:0]  ok_ref
);
  import dtg_pkg::*;

  localparam int CW       = TW + 2;  // room for the composite write spans
  localparam int FAW_SLOT = 4;

  // ---------------- timing configuration registers ----------------
  logic [TW-1:0] t_rc_q, t_rp_q, t_rfc_q, t_rrd_q, t_faw_q, t_rcd_q, t_ccd_q;
  logic [TW-1:0] t_ras_q, t_rtp_q, t_wr_q, t_wtr_q, cl_q, bl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_rc_q  <= TW'(D_RC);   t_rp_q  <= TW'(D_RP);   t_rfc_q <= TW'(D_RFC);
      t_rrd_q <= TW'(D_RRD);  t_faw_q <= TW'(D_FAW);  t_rcd_q <= TW'(D_RCD);
      t_ccd_q <= TW'(D_CCD);  t_ras_q <= TW'(D_RAS);  t_rtp_q <= TW'(D_RTP);
      t_wr_q  <= TW'(D_WR);   t_wtr_q <= TW'(D_WTR);  cl_q    <= TW'(D_CL);
      bl_q    <= TW'(D_BL);
    end else if (cfg_load) begin
      t_rc_q  <= cfg_t_rc;   t_rp_q  <= cfg_t_rp;   t_rfc_q <= cfg_t_rfc;
      t_rrd_q <= cfg_t_rrd;  t_faw_q <= cfg_t_faw;  t_rcd_q <= cfg_t_rcd;
      t_ccd_q <= cfg_t_ccd;  t_ras_q <= cfg_t_ras;  t_rtp_q <= cfg_t_rtp;
      t_wr_q  <= cfg_t_wr;   t_wtr_q <= cfg_t_wtr;  cl_q    <= cfg_cl;
      bl_q    <= cfg_bl;
    end
  end

  // ---------------- countdown preload values ----------------
  logic [CW-1:0] v_rc, v_rp, v_rfc, v_rrd, v_faw, v_rcd, v_ccd;
  logic [CW-1:0] v_ras, v_rtp, v_wtr, v_wrr;

  assign v_rc  = CW'(win_load(32'(t_rc_q)));
  assign v_rp  = CW'(win_load(32'(t_rp_q)));
  assign v_rfc = CW'(win_load(32'(t_rfc_q)));
  assign v_rrd = CW'(win_load(32'(t_rrd_q)));
  assign v_faw = CW'(win_load(32'(t_faw_q)));
  assign v_rcd = CW'(win_load(32'(t_rcd_q)));
  assign v_ccd = CW'(win_load(32'(t_ccd_q)));
  assign v_ras = CW'(win_load(32'(t_ras_q)));
  assign v_rtp = CW'(win_load(32'(t_rtp_q)));
  assign v_wtr = CW'(win_load(wr_to_rd_span(32'(cl_q), 32'(bl_q), 32'(t_wtr_q))));
  assign v_wrr = CW'(win_load(wr_to_pre_span(32'(cl_q), 32'(bl_q), 32'(t_wr_q))));

  // ---------------- command decode (named events) ----------------
  dram_cmd_e cmd_kind;
  logic      act_issue, rd_issue, wr_issue, pre_issue, ref_issue, col_issue;

  assign cmd_kind  = dram_cmd_e'(cmd_type);
  assign act_issue = cmd_valid && (cmd_kind == CMD_ACT);
  assign rd_issue  = cmd_valid && (cmd_kind == CMD_RD);
  assign wr_issue  = cmd_valid && (cmd_kind == CMD_WR);
  assign pre_issue = cmd_valid && (cmd_kind == CMD_PRE);
  assign ref_issue = cmd_valid && (cmd_kind == CMD_REF);
  assign col_issue = rd_issue || wr_issue;

  // ---------------- shared (cross-bank) windows ----------------
  logic [CW-1:0] rrd_cnt, ccd_cnt;
  logic          rrd_free, ccd_free, faw_free;

  dtg_countdown #(.W(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .ld(act_issue), .ld_val(v_rrd),
    .cnt(rrd_cnt), .expired(rrd_free));

  dtg_countdown #(.W(CW)) u_ccd (
    .clk(clk), .rst_n(rst_n), .ld(col_issue), .ld_val(v_ccd),
    .cnt(ccd_cnt), .expired(ccd_free));

  dtg_faw_window #(.DEPTH(FAW_SLOT), .CW(CW)) u_faw (
    .clk(clk), .rst_n(rst_n), .act(act_issue), .ld_val(v_faw),
    .slot_free(faw_free));

  // ---------------- per-bank windows ----------------
  logic [NB-1:0] row_free, rdg_free, wrg_free, preg_free;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = (cmd_bank == BAW'(b));

    dtg_bank_timers #(.CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_hit(act_issue && bank_sel), .pre_hit(pre_issue && bank_sel),
      .rd_hit(rd_issue && bank_sel),   .wr_hit(wr_issue && bank_sel),
      .ref_any(ref_issue),
      .v_rc(v_rc), .v_rp(v_rp), .v_rfc(v_rfc), .v_rcd(v_rcd), .v_wtr(v_wtr),
      .v_ras(v_ras), .v_rtp(v_rtp), .v_wrr(v_wrr),
      .act_free(row_free[b]), .rd_free(rdg_free[b]),
      .wr_free(wrg_free[b]),  .pre_free(preg_free[b]));

    assign ok_act[b] = row_free[b] && rrd_free && faw_free;
    assign ok_ref[b] = row_free[b];
    assign ok_rd[b]  = rdg_free[b] && ccd_free;
    assign ok_wr[b]  = wrg_free[b] && ccd_free;
    assign ok_pre[b] = preg_free[b];
  end

  // ---------------- assertions ----------------
  p_act_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |-> ok_act[cmd_bank]);
  p_rd_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> ok_rd[cmd_bank]);
  p_wr_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |-> ok_wr[cmd_bank]);
  p_pre_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_issue |-> ok_pre[cmd_bank]);
  p_rrd_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_issue && t_rrd_q > TW'(1)) |=> (ok_act == '0));
  p_ccd_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_issue && t_ccd_q > TW'(1)) |=> (ok_rd == '0 && ok_wr == '0));
  p_cfg_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (t_rc_q == $past(cfg_t_rc) && t_faw_q == $past(cfg_t_faw)
                  && cl_q == $past(cfg_cl)));

endmodule

// File: tb/dram_timing_guard_tb.sv
module dram_timing_guard_tb;
  localparam int NB  = 8;
  localparam int TW  = 6;
  localparam int BAW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           cmd_valid = 1'b0;
  logic [2:0]     cmd_type = 3'd0;
  logic [BAW-1:0] cmd_bank = '0;
  logic           cfg_load = 1'b0;
  logic [TW-1:0]  c_rc = 6, c_rp = 2, c_rfc = 20, c_rrd = 1, c_faw = 14, c_rcd = 1;
  logic [TW-1:0]  c_ccd = 1, c_ras = 4, c_rtp = 0, c_wr = 5, c_wtr = 4, c_cl = 5, c_bl = 8;
  logic [NB-1:0]  ok_act, ok_rd, ok_wr, ok_pre, ok_ref;

  dram_timing_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cfg_load(cfg_load),
    .cfg_t_rc(c_rc), .cfg_t_rp(c_rp), .cfg_t_rfc(c_rfc), .cfg_t_rrd(c_rrd),
    .cfg_t_faw(c_faw), .cfg_t_rcd(c_rcd), .cfg_t_ccd(c_ccd), .cfg_t_ras(c_ras),
    .cfg_t_rtp(c_rtp), .cfg_t_wr(c_wr), .cfg_t_wtr(c_wtr), .cfg_cl(c_cl), .cfg_bl(c_bl),
    .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr), .ok_pre(ok_pre), .ok_ref(ok_ref));

  int checks = 0;
  int errors = 0;
  longint now = 0;

  // reference timing set (defaults first)
  int p_rc = 10, p_rp = 3, p_rfc = 12, p_rrd = 2, p_faw = 9, p_rcd = 3, p_ccd = 2;
  int p_ras = 7, p_rtp = 2, p_wr = 3, p_wtr = 2, p_cl = 3, p_bl = 4;

  longint last_act[NB], last_pre[NB], last_rd[NB], last_wr[NB];
  longint last_ref, last_col;
  longint hist[4];

  function automatic int data_done();
    return ((p_cl > 0) ? p_cl - 1 : 0) + p_bl / 2;
  endfunction

  function automatic bit m_row(input int b);
    return (now - last_act[b] >= p_rc) && (now - last_pre[b] >= p_rp) && (now - last_ref >= p_rfc);
  endfunction
  function automatic bit m_act(input int b);
    return m_row(b) && (now - hist[0] >= p_rrd) && (now - hist[3] >= p_faw);
  endfunction
  function automatic bit m_rd(input int b);
    return (now - last_act[b] >= p_rcd) && (now - last_wr[b] >= data_done() + p_wtr)
           && (now - last_col >= p_ccd);
  endfunction
  function automatic bit m_wr(input int b);
    return (now - last_act[b] >= p_rcd) && (now - last_col >= p_ccd);
  endfunction
  function automatic bit m_pre(input int b);
    return (now - last_act[b] >= p_ras) && (now - last_rd[b] >= p_rtp)
           && (now - last_wr[b] >= data_done() + p_wr);
  endfunction
  function automatic bit m_legal(input int t, input int b);
    case (t)
      1: return m_act(b);
      2: return m_rd(b);
      3: return m_wr(b);
      4: return m_pre(b);
      5: return m_row(b);
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_reset();
    now = 0;
    for (int b = 0; b < NB; b++) begin
      last_act[b] = -1000; last_pre[b] = -1000; last_rd[b] = -1000; last_wr[b] = -1000;
    end
    last_ref = -1000; last_col = -1000;
    for (int i = 0; i < 4; i++) hist[i] = -1000;
  endtask

  task automatic model_issue(input int t, input int b);
    case (t)
      1: begin
        last_act[b] = now;
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = now;
      end
      2: begin last_rd[b] = now; last_col = now; end
      3: begin last_wr[b] = now; last_col = now; end
      4: last_pre[b] = now;
      5: last_ref = now;
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, now, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] e_act, e_rd, e_wr, e_pre, e_ref;
    for (int b = 0; b < NB; b++) begin
      e_act[b] = m_act(b); e_rd[b] = m_rd(b); e_wr[b] = m_wr(b);
      e_pre[b] = m_pre(b); e_ref[b] = m_row(b);
    end
    chk(ok_act == e_act, "R2/R3/R4", "ok_act", ok_act, e_act);
    chk(ok_ref == e_ref, "R2", "ok_ref", ok_ref, e_ref);
    chk(ok_rd == e_rd, "R5/R7", "ok_rd", ok_rd, e_rd);
    chk(ok_wr == e_wr, "R6/R7", "ok_wr", ok_wr, e_wr);
    chk(ok_pre == e_pre, "R8", "ok_pre", ok_pre, e_pre);
  endtask

  // Called just after a falling edge: check, drive, advance one cycle.
  task automatic step(input bit v, input int t, input int b);
    compare_all();
    cmd_valid = v;
    cmd_type  = 3'(t);
    cmd_bank  = BAW'(b);
    if (v) model_issue(t, b);
    @(posedge clk);
    now++;
    @(negedge clk);
  endtask

  task automatic random_run(input int cycles);
    for (int n = 0; n < cycles; n++) begin
      int t = int'($urandom_range(5, 1));
      int b = int'($urandom_range(NB - 1, 0));
      if ($urandom_range(9, 0) < 7 && m_legal(t, b)) step(1'b1, t, b);
      else                                            step(1'b0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, every flag legal
    chk(ok_act == '1 && ok_rd == '1 && ok_wr == '1 && ok_pre == '1 && ok_ref == '1,
        "R1", "reset flags", {ok_act, ok_rd, ok_wr, ok_pre, ok_ref}, {5 * NB{1'b1}});

    // R9 / R5 / R6: activate bank 0, watch the exact tRCD boundary
    step(1'b1, 1, 0);
    for (int k = 1; k <= 5; k++) begin
      chk(ok_rd[0] == (k >= p_rcd), "R9", "ok_rd[0] vs tRCD", ok_rd[0], (k >= p_rcd));
      chk(ok_wr[0] == (k >= p_rcd), "R6", "ok_wr[0] vs tRCD", ok_wr[0], (k >= p_rcd));
      step(1'b0, 0, 0);
    end

    // R4 / R3: four activates as soon as allowed, then the fifth must wait
    for (int b = 1; b <= 4; b++) begin
      while (!m_act(b)) step(1'b0, 0, 0);
      step(1'b1, 1, b);
    end
    for (int k = 0; k < 12; k++) begin
      chk(ok_act[5] == m_act(5), "R4", "ok_act[5] four-activate window", ok_act[5], m_act(5));
      step(1'b0, 0, 0);
    end

    random_run(3000);

    // R10: drain, then load a new timing set
    repeat (200) step(1'b0, 0, 0);
    compare_all();
    cfg_load = 1'b1;
    @(posedge clk); now++; @(negedge clk);
    cfg_load = 1'b0;
    p_rc = 6; p_rp = 2; p_rfc = 20; p_rrd = 1; p_faw = 14; p_rcd = 1; p_ccd = 1;
    p_ras = 4; p_rtp = 0; p_wr = 5; p_wtr = 4; p_cl = 5; p_bl = 8;

    // R10 / R9: with tRCD=1 and tCCD=1 a column command is legal the next cycle
    step(1'b1, 1, 6);
    chk(ok_rd[6] == 1'b1, "R10", "ok_rd[6] after tRCD=1", ok_rd[6], 1);
    step(1'b1, 3, 6);
    chk(ok_wr[6] == 1'b1, "R7", "ok_wr[6] after tCCD=1", ok_wr[6], 1);
    chk(ok_rd[6] == 1'b0, "R5", "ok_rd[6] write turnaround", ok_rd[6], 0);
    chk(ok_pre[6] == 1'b0, "R8", "ok_pre[6] write recovery", ok_pre[6], 0);

    random_run(3000);
    repeat (60) step(1'b0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule